// File: doc/BRIEF.md
# Flag-Conditioned Microcode Sequencer

This block is the control sequencer of a microcoded 8-bit processor. It holds the opcode of the instruction being executed and a phase counter, and on every clock it presents one microinstruction. The microinstruction is read from a built-in table. The table address is formed from the opcode, the current phase and the current carry flag. A phase can therefore hold one line that ignores the carry, or two alternative lines, one for carry clear and one for carry set.

Each instruction has at most sixteen phases, and one phase lasts one clock. When a microinstruction has its end bit set, the next clock starts phase 0 of the opcode offered by the fetch path. An instruction that reaches its last phase without an end bit is cut off. The sequencer then returns to the fetch opcode and raises an error output for exactly one cycle. The built-in table holds a few test instructions that exercise these paths. Every opcode outside those few finishes in one phase.

Top module: `ucode_sequencer`

## Requirements
- R1: Reset is asserted asynchronously and released on the clock. While it is active, the phase is 0, the current opcode is the fetch opcode 0x00 and the error output is low.
- R2: The microcode address is {opcode[7:0], phase[3:0], carry}, with carry in bit 0. It follows a change of carry in the same cycle.
- R3: On a line that does not depend on the flag, the microword is the same for carry 0 and carry 1. Its variant bit (bit 4) is 0.
- R4: Opcode 0x02 is conditional at phase 1. With carry set, that line ends the instruction and has variant bit 1. With carry clear, it continues to phase 2, which ends. Opcode 0x03 is conditional at phase 7, and its variant bit there equals the carry.
- R5: When the end bit (bit 15) is 1, the next clock sets the phase to 0 and loads the opcode from the fetch input.
- R6: When the end bit is 0 and the phase is below 15, the next clock adds one to the phase and keeps the opcode.
- R7: Opcode 0x03 runs all 16 phases and ends at phase 15 with no error. Opcode 0x00 and every unlisted opcode other than 0x01 to 0x04 end at phase 0. Opcode 0x01 ends at phase 1.
- R8: If the phase is 15 and the end bit is 0, as with opcode 0x04, the next clock sets the phase to 0 and the opcode to 0x00. The error output is then high for exactly that one cycle.
- R9: Microword bits 14:9 carry opcode[5:0], bits 8:5 carry the phase, and bits 3:0 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| carry | input | 1 | Current carry flag |
| fetch_op | input | 8 | Next opcode from the fetch path |
| opcode | output | 8 | Opcode being executed |
| phase | output | 4 | Current phase number |
| uaddr | output | 13 | Microcode table address |
| uword | output | 16 | Current microinstruction; bit 15 is the end bit |
| seq_err | output | 1 | One-cycle pulse after a phase overflow |

## Verification
The carry and the fetched opcodes are drawn at random, weighted toward the test instructions. This mix produces short, two-phase, branching, full-length and runaway instructions in many different orders. The bench also flips the carry within a cycle to tell flag-dependent lines from unconditional ones. Directed runs feed the runaway and full-length opcodes back to back. These runs separate a legal ending at phase 15 from an overflow, and a one-cycle error pulse from one that sticks.

// File: rtl/ucode_sequencer.sv
module ucode_sequencer #(
  parameter int OPW = 8,
  parameter int PHW = 4,
  parameter logic [7:0] FETCH_OP = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   carry,
  input  logic [OPW-1:0]         fetch_op,
  output logic [OPW-1:0]         opcode,
  output logic [PHW-1:0]         phase,
  output logic [OPW+PHW:0]       uaddr,
  output logic [PHW+11:0]        uword,
  output logic                   seq_err
);
  localparam int AW = OPW + PHW + 1;
  localparam int WW = PHW + 12;
  localparam logic [PHW-1:0] LAST_PH = {PHW{1'b1}};

  function automatic logic [WW-1:0] rom_word(input logic [AW-1:0] a);
    logic [OPW-1:0] op;
    logic [PHW-1:0] ph;
    logic c, fin, var_b;
    op = a[AW-1 -: OPW];
    ph = a[PHW:1];
    c = a[0];
    fin = 1'b0;
    var_b = 1'b0;
    case (op)
      8'h01: fin = (ph == 1);
      8'h02: begin
        if (ph == 1) begin
          fin = c;
          var_b = c;
        end else begin
          fin = (ph == 2);
        end
      end
      8'h03: begin
        fin = (ph == LAST_PH);
        if (ph == 7) var_b = c;
      end
      8'h04: fin = 1'b0;
      default: fin = (ph == 0);
    endcase
    rom_word = {fin, op[5:0], ph, var_b, 4'b0000};
  endfunction

  logic fin_bit, overflow;

  assign uaddr    = {opcode, phase, carry};
  assign uword    = rom_word(uaddr);
  assign fin_bit  = uword[WW-1];
  assign overflow = !fin_bit && (phase == LAST_PH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      opcode  <= FETCH_OP;
      seq_err <= 1'b0;
    end else begin
      seq_err <= overflow;
      if (fin_bit) begin
        phase  <= '0;
        opcode <= fetch_op;
      end else if (overflow) begin
        phase  <= '0;
        opcode <= FETCH_OP;
      end else begin
        phase  <= phase + 1'b1;
      end
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fin_bit && phase != LAST_PH) |=> (phase == $past(phase) + 1'b1) && $stable(opcode)); // R6
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fin_bit |=> (phase == '0) && (opcode == $past(fetch_op))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> seq_err && (opcode == FETCH_OP) && (phase == '0)); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> !seq_err); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |-> (phase == '0) && (opcode == FETCH_OP) && !seq_err); // R1
endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carry = 1'b0;
  logic [7:0] fetch_op = 8'h00;
  logic [7:0] opcode;
  logic [3:0] phase;
  logic [12:0] uaddr;
  logic [15:0] uword;
  logic seq_err;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [7:0] m_op;
  logic [3:0] m_ph;
  logic m_err;

  ucode_sequencer dut (.clk(clk), .rst_n(rst_n), .carry(carry), .fetch_op(fetch_op),
    .opcode(opcode), .phase(phase), .uaddr(uaddr), .uword(uword), .seq_err(seq_err));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic ends(input logic [7:0] op, input logic [3:0] ph, input logic c);
    case (op)
      8'h01: ends = (ph == 1);
      8'h02: ends = (ph == 1) ? c : (ph == 2);
      8'h03: ends = (ph == 15);
      8'h04: ends = 1'b0;
      default: ends = (ph == 0);
    endcase
  endfunction

  function automatic logic is_cond(input logic [7:0] op, input logic [3:0] ph);
    is_cond = (op == 8'h02 && ph == 1) || (op == 8'h03 && ph == 7);
  endfunction

  function automatic logic [15:0] exp_word(input logic [7:0] op, input logic [3:0] ph, input logic c);
    exp_word = {ends(op, ph, c), op[5:0], ph, is_cond(op, ph) ? c : 1'b0, 4'b0000};
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (op %h ph %0d)", tag, act, exp, m_op, m_ph);
    end
  endtask

  task automatic step(input logic [7:0] fop, input logic c);
    logic [15:0] w0, w1;
    logic e, ovf;
    string tg;
    @(negedge clk);
    fetch_op = fop;
    carry = c;
    #1;
    check(uaddr == {m_op, m_ph, c}, "R2", 32'(uaddr), 32'({m_op, m_ph, c}));
    check(phase == m_ph && opcode == m_op, "R6", 32'({opcode, phase}), 32'({m_op, m_ph}));
    check(seq_err == m_err, "R8", 32'(seq_err), 32'(m_err));
    tg = is_cond(m_op, m_ph) ? "R4" : (m_op == 8'h03 ? "R7" : "R9");
    check(uword == exp_word(m_op, m_ph, c), tg, 32'(uword), 32'(exp_word(m_op, m_ph, c)));
    w0 = uword;
    carry = ~c;
    #1;
    check(uaddr[0] == ~c, "R2", 32'(uaddr[0]), 32'(~c));
    w1 = uword;
    if (!is_cond(m_op, m_ph))
      check(w0 == w1 && w0[4] == 1'b0, "R3", 32'(w1), 32'(w0));
    carry = c;
    #1;
    e = ends(m_op, m_ph, c);
    ovf = !e && m_ph == 15;
    @(posedge clk);
    #1;
    m_err = ovf;
    if (e) begin
      m_ph = 0;
      m_op = fop;
    end else if (ovf) begin
      m_ph = 0;
      m_op = 8'h00;
    end else begin
      m_ph = m_ph + 1;
    end
    if (e) check(phase == 0 && opcode == fop, "R5", 32'({opcode, phase}), 32'({fop, 4'h0}));
    if (ovf) check(seq_err && opcode == 8'h00 && phase == 0, "R8", 32'({seq_err, opcode, phase}), 32'h1000);
  endtask

  initial begin
    logic [7:0] fop;
    void'($urandom(32'd1357));
    m_op = 8'h00;
    m_ph = 0;
    m_err = 1'b0;
    #3;
    check(phase == 0 && opcode == 8'h00 && seq_err == 1'b0, "R1", 32'({seq_err, opcode, phase}), 32'h0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(phase == 0 && opcode == 8'h00, "R1", 32'({opcode, phase}), 32'h0);
    step(8'h03, 1'b0);
    for (int i = 0; i < 16; i++) step(8'h04, i[0]);
    for (int i = 0; i < 17; i++) step(8'h02, 1'b1);
    step(8'h02, 1'b0);
    step(8'h02, 1'b1);
    step(8'h02, 1'b0);
    step(8'h01, 1'b0);
    step(8'h55, 1'b1);
    step(8'h03, 1'b0);
    for (int i = 0; i < 600; i++) begin
      fop = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 5);
      step(fop, 1'($urandom));
    end
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(phase == 0 && opcode == 8'h00 && seq_err == 1'b0, "R1", 32'({seq_err, opcode, phase}), 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule